// File: doc/BRIEF.md
# Output Channel Word Disassembler

This block drives one outgoing parcel channel from word memory. Software-side logic first loads a current address and a limit address. It then pulses a start input. The block reads 64-bit words from a memory port, one word per address, beginning at the current address. It stops before the word at the limit address. Each word is cut into four 16-bit parcels and sent most-significant parcel first. Every parcel carries four parity bits, one for each nibble.

Each parcel is offered with a ready line and stays on the channel until the receiver answers with resume. After the last parcel of the last word, the block pulses disconnect for one cycle and goes back to idle. Between words, it requests the following word while the current word is still being sent. With a prompt memory and a receiver that holds resume high, parcels leave on every cycle, with no gap at word boundaries. A master clear input abandons any transfer at once.

Top module: `chanDisasm`

## Requirements
- R1: After reset, and in the cycle after master clear is asserted, ready and disconnect are low and no transfer continues.
- R2: A start while idle, with current address unequal to limit address, raises memReq combinationally in the same cycle with memAddr equal to the current address.
- R3: The parcels of a word appear in order word[63:48], word[47:32], word[31:16], word[15:0].
- R4: Parity bit i of the channel is odd parity over data bits 4i+3..4i (bit set when that nibble has an even number of ones).
- R5: While ready is high and resume is low, ready stays high and the parcel data does not change.
- R6: Words are read in rising address order, one request each, and the next word's request (address current+1) goes out during the third parcel of the current word; a response that arrives before the fourth parcel is accepted is held until it is needed.
- R7: With resume held high and a memory that answers one cycle after each request, ready stays high from the first parcel to the last with no idle cycle between words.
- R8: One cycle after the last parcel of the word at limit−1 is accepted, disconnect is high for exactly one cycle with ready low, and the block is then idle.
- R9: A start while current address equals limit address issues no memory request and gives the one-cycle disconnect pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterClr | input | 1 | Synchronous abort back to idle |
| loadAddr | input | 1 | Load current and limit addresses (idle only) |
| loadCur | input | ADDR_W | Current address value to load |
| loadLim | input | ADDR_W | Limit address value to load |
| start | input | 1 | Begin a transfer (idle only) |
| memReq | output | 1 | Memory read request, one cycle per word |
| memAddr | output | ADDR_W | Word address of the request |
| memRspValid | input | 1 | Read data valid, one pulse per request |
| memRspData | input | WORD_W | Read data word |
| chData | output | PARCEL_W | Parcel data on the channel |
| chParity | output | PARCEL_W/4 | Odd parity per nibble of chData |
| chReady | output | 1 | Parcel on the channel is valid |
| chResume | input | 1 | Receiver takes the parcel at this edge |
| chDisc | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that memory answers every request with exactly one memRspValid pulse and never answers without a request. They also assume that at most one read is outstanding, and that start and loadAddr are only pulsed while the block is idle. The bench memory model registers each request and replies exactly one cycle later with a word taken from its table. The stimulus issues start and address loads only after reset, after disconnect, or after a master clear. Resume is driven in three patterns: held high, held low for a stall, and alternated every other cycle so that the held-response path is used.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef struct packed {
    logic ldAddr;     // capture current/limit addresses
    logic ldWordMem;  // fill disassembly register from memory response
    logic ldWordBuf;  // fill disassembly register from prefetch buffer
    logic capNext;    // park an early response in the prefetch buffer
    logic incCur;     // step current address after last parcel
  } dpStrobe_t;
endpackage

// File: rtl/chanDatapath.sv
module chanDatapath
  import chan_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WORD_W   = 64,
  parameter int PARCEL_W = 16,
  parameter int GROUP_W  = 4,
  localparam int NPARCEL = WORD_W / PARCEL_W,
  localparam int NGROUP  = PARCEL_W / GROUP_W,
  localparam int IDX_W   = (NPARCEL > 1) ? $clog2(NPARCEL) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ADDR_W-1:0]   loadCur,
  input  logic [ADDR_W-1:0]   loadLim,
  input  logic [WORD_W-1:0]   memRspData,
  input  logic [IDX_W-1:0]    idx,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [ADDR_W-1:0]   nextAddr,
  output logic                curAtLim,
  output logic                nextAtLim,
  output logic [PARCEL_W-1:0] parcel,
  output logic [NGROUP-1:0]   parity
);
  logic [ADDR_W-1:0]   limAddr;
  logic [WORD_W-1:0]   disReg;
  logic [WORD_W-1:0]   nextBuf;
  logic [PARCEL_W-1:0] slice [NPARCEL];

  assign nextAddr  = curAddr + ADDR_W'(1);
  assign curAtLim  = (curAddr == limAddr);
  assign nextAtLim = (nextAddr == limAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      limAddr <= '0;
    end else if (strobe.ldAddr) begin
      curAddr <= loadCur;
      limAddr <= loadLim;
    end else if (strobe.incCur) begin
      curAddr <= nextAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disReg  <= '0;
      nextBuf <= '0;
    end else begin
      if (strobe.ldWordMem)      disReg <= memRspData;
      else if (strobe.ldWordBuf) disReg <= nextBuf;
      if (strobe.capNext)        nextBuf <= memRspData;
    end
  end

  // parcel 0 is the most significant slice of the word
  for (genvar k = 0; k < NPARCEL; k++) begin : g_slice
    assign slice[k] = disReg[WORD_W-1-k*PARCEL_W -: PARCEL_W];
  end

  assign parcel = slice[idx];

  for (genvar g = 0; g < NGROUP; g++) begin : g_par
    assign parity[g] = ~^parcel[g*GROUP_W +: GROUP_W];
  end
endmodule

// File: rtl/chanControl.sv
module chanControl
  import chan_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int PARCEL_W = 16,
  localparam int NPARCEL = WORD_W / PARCEL_W,
  localparam int IDX_W   = (NPARCEL > 1) ? $clog2(NPARCEL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterClr,
  input  logic             loadAddr,
  input  logic             start,
  input  logic             resume,
  input  logic             curAtLim,
  input  logic             nextAtLim,
  input  logic             memRspValid,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] idx,
  output logic             memReq,
  output logic             reqNext,
  output logic             ready,
  output logic             disc
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPARCEL - 1);
  localparam logic [IDX_W-1:0] PF_IDX   = IDX_W'((NPARCEL > 1) ? NPARCEL - 2 : 0);

  typedef enum logic [1:0] {IDLE, WAIT, SEND, DISC} state_t;
  state_t state;
  logic   pfIssued, nextValid;
  logic   lastHs, firstReq, pfReq;

  assign lastHs   = (state == SEND) && resume && (idx == LAST_IDX);
  assign firstReq = (state == IDLE) && start && !curAtLim;
  assign pfReq    = (state == SEND) && (idx >= PF_IDX) && !pfIssued && !nextAtLim;

  always_comb begin
    memReq           = !masterClr && (firstReq || pfReq);
    reqNext          = pfReq;
    strobe           = '0;
    if (!masterClr) begin
      strobe.ldAddr    = (state == IDLE) && loadAddr;
      strobe.incCur    = lastHs;
      strobe.ldWordMem = memRspValid && ((state == WAIT) || (lastHs && !nextValid));
      strobe.ldWordBuf = lastHs && nextValid;
      strobe.capNext   = memRspValid && (state == SEND) && !lastHs;
    end
  end

  assign ready = (state == SEND);
  assign disc  = (state == DISC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= IDLE;
      idx       <= '0;
      pfIssued  <= 1'b0;
      nextValid <= 1'b0;
    end else if (masterClr) begin
      state     <= IDLE;
      idx       <= '0;
      pfIssued  <= 1'b0;
      nextValid <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (start) state <= curAtLim ? DISC : WAIT;
        WAIT: if (memRspValid) begin
          state    <= SEND;
          idx      <= '0;
          pfIssued <= 1'b0;
        end
        SEND: begin
          if (pfReq)        pfIssued  <= 1'b1;
          if (strobe.capNext) nextValid <= 1'b1;
          if (resume) begin
            if (idx == LAST_IDX) begin
              idx       <= '0;
              pfIssued  <= 1'b0;
              nextValid <= 1'b0;
              if (nextAtLim)                     state <= DISC;
              else if (nextValid || memRspValid) state <= SEND;
              else                               state <= WAIT;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        DISC: state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  // R5
  hold_parcel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !resume && !masterClr) |=> (ready && $stable(idx)));
  // R8
  disc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    disc |=> !disc);
  // R1
  mclr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> (!ready && !disc));
  // R6
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
endmodule

// File: rtl/chanDisasm.sv
module chanDisasm
  import chan_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WORD_W   = 64,
  parameter int PARCEL_W = 16,
  localparam int GROUP_W = 4,
  localparam int NGROUP  = PARCEL_W / GROUP_W,
  localparam int NPARCEL = WORD_W / PARCEL_W,
  localparam int IDX_W   = (NPARCEL > 1) ? $clog2(NPARCEL) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterClr,
  input  logic                loadAddr,
  input  logic [ADDR_W-1:0]   loadCur,
  input  logic [ADDR_W-1:0]   loadLim,
  input  logic                start,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic                memRspValid,
  input  logic [WORD_W-1:0]   memRspData,
  output logic [PARCEL_W-1:0] chData,
  output logic [NGROUP-1:0]   chParity,
  output logic                chReady,
  input  logic                chResume,
  output logic                chDisc
);
  dpStrobe_t         strobe;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] curAddr, nextAddr;
  logic              curAtLim, nextAtLim, reqNext;

  chanControl #(.WORD_W(WORD_W), .PARCEL_W(PARCEL_W)) u_ctl (
    .clk, .rstN, .masterClr, .loadAddr, .start,
    .resume(chResume), .curAtLim, .nextAtLim, .memRspValid,
    .strobe, .idx, .memReq, .reqNext, .ready(chReady), .disc(chDisc)
  );

  chanDatapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PARCEL_W(PARCEL_W),
                 .GROUP_W(GROUP_W)) u_dp (
    .clk, .rstN, .strobe, .loadCur, .loadLim, .memRspData, .idx,
    .curAddr, .nextAddr, .curAtLim, .nextAtLim,
    .parcel(chData), .parity(chParity)
  );

  assign memAddr = reqNext ? nextAddr : curAddr;

  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chReady && !chResume && !masterClr) |=> ($stable(chData) && $stable(chParity)));
endmodule

// File: tb/sim_chanDisasm.sv
`timescale 1ns/1ps
module sim_chanDisasm;
  typedef struct packed { logic [63:0] word; logic [15:0] par; } vec_t;
  // word and expected parity (parcel 0 in the top nibble)
  localparam vec_t TBL [8] = '{
    '{64'h0000_0000_0000_0000, 16'hFFFF},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF},
    '{64'h1111_2222_4444_8888, 16'h0000},
    '{64'h0123_4567_89AB_CDEF, 16'h9669},
    '{64'hF0F0_0F0F_3C3C_A5A5, 16'hFFFF},
    '{64'h8421_1248_7BDE_EDB7, 16'h0000},
    '{64'hDEAD_BEEF_CAFE_F00D, 16'h21EE},
    '{64'h8000_0000_0000_0001, 16'h7FFE}
  };

  logic clk = 0, rstN = 0, masterClr = 0, loadAddr = 0, start = 0, chResume = 0;
  logic [15:0] loadCur = '0, loadLim = '0;
  logic memReq, memRspValid = 0, chReady, chDisc;
  logic [15:0] memAddr, chData;
  logic [63:0] memRspData = '0;
  logic [3:0]  chParity;
  int total = 0, bad = 0, reqCount = 0;

  always #2.5 clk = ~clk;

  chanDisasm u0 (.clk, .rstN, .masterClr, .loadAddr, .loadCur, .loadLim, .start,
    .memReq, .memAddr, .memRspValid, .memRspData, .chData, .chParity,
    .chReady, .chResume, .chDisc);

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    memRspValid <= memReq;
    memRspData  <= TBL[memAddr[2:0]].word;
    if (memReq) reqCount <= reqCount + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expData(input int w, input int k);
    return TBL[w].word[63-16*k -: 16];
  endfunction
  function automatic logic [3:0] expPar(input int w, input int k);
    return TBL[w].par[15-4*k -: 4];
  endfunction

  task automatic loadRange(input logic [15:0] c, input logic [15:0] l);
    @(negedge clk); loadAddr = 1; loadCur = c; loadLim = l;
    @(negedge clk); loadAddr = 0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 20 && !chReady; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int got, gaps, dataBad, parBad, base, err, discSeen;
    bit phase;
    logic [15:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!chReady && !chDisc && !memReq, "R1 reset outputs", {chReady, chDisc, memReq}, 0);
    rstN = 1;

    // main walk over the table: words 0..7, resume held high
    loadRange(16'd0, 16'd8);
    chResume = 1; base = reqCount;
    @(negedge clk); start = 1; #1;
    chk(memReq && memAddr == 0, "R2 first request", {memReq, memAddr}, {1'b1, 16'd0});
    @(negedge clk); start = 0;
    got = 0; gaps = 0; dataBad = 0; parBad = 0;
    for (int c = 0; c < 200 && got < 32; c++) begin
      @(negedge clk);
      if (chReady) begin
        if (chData != expData(got/4, got%4)) dataBad++;
        if (chParity != expPar(got/4, got%4)) parBad++;
        got++;
      end else if (got > 0) gaps++;
    end
    chk(got == 32, "R3 parcel count", got, 32);
    chk(dataBad == 0, "R3 parcel order", dataBad, 0);
    chk(parBad == 0, "R4 nibble parity", parBad, 0);
    chk(gaps == 0, "R7 no bubble", gaps, 0);
    chk(reqCount - base == 8, "R6 one request per word", reqCount - base, 8);
    @(negedge clk);
    chk(chDisc && !chReady, "R8 disconnect pulse", {chDisc, chReady}, 2'b10);
    @(negedge clk);
    chk(!chDisc && !chReady, "R8 pulse one cycle", {chDisc, chReady}, 0);

    // stall then alternating resume: words 2,3 via address 10..11
    loadRange(16'd10, 16'd12);
    chResume = 0;
    @(negedge clk); start = 1; #1;
    chk(memReq && memAddr == 10, "R2 request address", memAddr, 10);
    @(negedge clk); start = 0;
    waitReady();
    held = chData;
    err = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!chReady || chData != held) err++;
    end
    chk(err == 0, "R5 hold while no resume", chData, held);
    chk(held == expData(2, 0), "R3 first parcel", held, expData(2, 0));
    got = 0; err = 0; discSeen = 0; phase = 1;
    for (int c = 0; c < 100 && !discSeen; c++) begin
      if (chDisc) discSeen = 1;
      if (chReady) begin
        if (phase) begin
          if (chData != expData(2 + got/4, got%4) || chParity != expPar(2 + got/4, got%4)) err++;
          got++;
          chResume = 1;
        end else chResume = 0;
        phase = !phase;
      end else chResume = 0;
      @(negedge clk);
    end
    chResume = 0;
    chk(got == 8 && err == 0, "R6 buffered next word", {got[15:0], err[15:0]}, {16'd8, 16'd0});
    chk(discSeen == 1, "R8 disconnect after slow run", discSeen, 1);

    // master clear mid-word
    loadRange(16'd0, 16'd8);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    waitReady();
    masterClr = 1;
    @(negedge clk); masterClr = 0;
    chk(!chReady && !chDisc, "R1 master clear idle", {chReady, chDisc}, 0);
    repeat (3) @(negedge clk);
    chk(!chReady && !chDisc && !memReq, "R1 stays idle", {chReady, chDisc, memReq}, 0);

    // restart after clear: single word at address 4
    loadRange(16'd4, 16'd5);
    chResume = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    waitReady();
    chk(chData == expData(4, 0) && chParity == expPar(4, 0), "R3 restart parcel",
        chData, expData(4, 0));
    repeat (4) @(negedge clk);
    chk(chDisc && !chReady, "R8 single word disconnect", {chDisc, chReady}, 2'b10);
    chResume = 0;

    // empty range
    loadRange(16'd5, 16'd5);
    @(negedge clk); start = 1; #1;
    chk(!memReq, "R9 no request on empty range", memReq, 0);
    @(negedge clk); start = 0;
    chk(chDisc && !chReady, "R9 immediate disconnect", {chDisc, chReady}, 2'b10);
    @(negedge clk);
    chk(!chDisc, "R9 pulse one cycle", chDisc, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule